// File: doc/BRIEF.md
# Periodic Down-Counting Tick Timer

This block is a memory-mapped periodic timer built around a down counter. Software programs a reload value, picks the counting source and turns the timer on. The counter then moves down by one on every tick until it reaches zero. On the next tick it loads the reload value again. Each arrival at zero sets a sticky status flag, and when the interrupt is enabled it also sends out a single-cycle interrupt request.

The tick comes either from the core clock, which gives one tick per enabled cycle, or from a synchronous reference strobe, which gives one tick per enabled cycle in which the strobe is high. The status flag clears when the control register is read. Any write to the current-value register zeroes the counter and drops the flag without raising an interrupt. A reload value of zero parks the counter at zero at its next wrap.

The bus is a simple single-cycle read/write port with byte addresses. Read data is registered and shows up on the cycle after the read strobe.

Top module: `tick_timer`

## Requirements
- R1: After a synchronous reset, every register reads zero and `irq` is low, so the timer is disabled with the counter at zero.
- R2: Registers sit at byte address 0x0 (control), 0x4 (reload) and 0x8 (current value). In the control register, bit 0 is enable, bit 1 is interrupt enable, bit 2 is the source (1 = core clock, 0 = reference strobe) and bit 16 is the status flag. Unused bits, address 0xC and misaligned addresses read zero. Read data appears on `bus_rdata` one cycle after `bus_rd` and is zero when no read was made.
- R3: While enabled, the counter drops by one on each tick. A tick is every cycle in core-clock mode, and only cycles with `ref_tick` high in strobe mode.
- R4: A tick that finds the counter at zero loads the reload value.
- R5: The status flag is set when a tick moves the counter from 1 to 0, and it stays set until it is cleared.
- R6: A control read returns the flag's prior value and clears it, unless a 1-to-0 move happens in the same cycle, in which case the flag stays set.
- R7: A write to the current-value register, whatever its data, zeroes the counter, clears the flag and raises no interrupt. It wins over a tick in the same cycle.
- R8: With the reload value at zero, a counter that reaches zero stays at zero.
- R9: `irq` is a one-cycle pulse, high in the cycle after a tick moves the counter from 1 to 0, and only when interrupt enable is set.
- R10: With enable clear, the counter holds its value.
- R11: The reload and current-value registers keep CNT_W bits. Higher write-data bits are dropped and read back as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_tick | input | 1 | Synchronous reference strobe, counted in strobe mode |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Registered read data |
| irq | output | 1 | Single-cycle interrupt request |

## Verification
The bench builds the timer with CNT_W set to 8. At that width a full-scale reload of 255 wraps within a short run. It also means a write of 0x1FF exercises how high data bits are dropped. The default DATA_W of 32 and ADDR_W of 4 are kept, so the status flag still sits at bit 16 and the unused fourth word and misaligned addresses are reachable. With the short counter, a long random mix of strobe ticks, reload changes, current-value writes and flag reads crosses many wraps. That mix hits same-cycle collisions between a flag read and a 1-to-0 move, and between a write and a tick.

// File: rtl/tick_timer_pkg.sv
package tick_timer_pkg;

  // word indexes (byte address >> 2)
  localparam int unsigned IDX_CTRL   = 0;
  localparam int unsigned IDX_RELOAD = 1;
  localparam int unsigned IDX_CUR    = 2;

  // control register bit positions
  localparam int unsigned BIT_EN     = 0;
  localparam int unsigned BIT_IE     = 1;
  localparam int unsigned BIT_SRC    = 2;
  localparam int unsigned BIT_FLAG   = 16;

  typedef struct packed {
    logic src_core;
    logic irq_en;
    logic run;
  } ctrl_t;

endpackage

// File: rtl/tick_gate.sv
module tick_gate (
  input  logic run,
  input  logic src_core,
  input  logic ref_tick,
  output logic tick
);

  always_comb begin
    tick = run & (src_core | ref_tick);
  end

endmodule

// File: rtl/tick_core.sv
module tick_core #(
  parameter int unsigned CNT_W = 24
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             clr,
  input  logic [CNT_W-1:0] reload,
  output logic [CNT_W-1:0] cnt,
  output logic             hit
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic at_zero;

  always_comb begin
    at_zero = (cnt == '0);
    hit     = tick & ~clr & (cnt == ONE);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (clr) begin
      cnt <= '0;
    end else if (tick) begin
      if (at_zero) cnt <= reload;
      else         cnt <= cnt - ONE;
    end
  end

endmodule

// File: rtl/tick_regs.sv
module tick_regs
  import tick_timer_pkg::*;
#(
  parameter int unsigned CNT_W  = 24,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic [CNT_W-1:0]  cnt,
  input  logic              hit,
  output ctrl_t             ctrl,
  output logic [CNT_W-1:0]  reload,
  output logic              flag,
  output logic              cur_wr,
  output logic              ctrl_rd,
  output logic [DATA_W-1:0] rdata,
  output logic              irq
);

  localparam int unsigned IDX_W = ADDR_W - 2;

  logic             aligned;
  logic [IDX_W-1:0] idx;
  logic             sel_ctrl, sel_rel, sel_cur;
  logic [DATA_W-1:0] rd_mux;

  always_comb begin
    aligned  = (bus_addr[1:0] == 2'b00);
    idx      = bus_addr[ADDR_W-1:2];
    sel_ctrl = aligned & (idx == IDX_W'(IDX_CTRL));
    sel_rel  = aligned & (idx == IDX_W'(IDX_RELOAD));
    sel_cur  = aligned & (idx == IDX_W'(IDX_CUR));
    cur_wr   = bus_wr & sel_cur;
    ctrl_rd  = bus_rd & sel_ctrl;
  end

  always_comb begin
    rd_mux = '0;
    if (sel_ctrl) begin
      rd_mux[BIT_EN]   = ctrl.run;
      rd_mux[BIT_IE]   = ctrl.irq_en;
      rd_mux[BIT_SRC]  = ctrl.src_core;
      rd_mux[BIT_FLAG] = flag;
    end else if (sel_rel) begin
      rd_mux[CNT_W-1:0] = reload;
    end else if (sel_cur) begin
      rd_mux[CNT_W-1:0] = cnt;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl   <= '0;
      reload <= '0;
    end else if (bus_wr) begin
      if (sel_ctrl) begin
        ctrl.run      <= bus_wdata[BIT_EN];
        ctrl.irq_en   <= bus_wdata[BIT_IE];
        ctrl.src_core <= bus_wdata[BIT_SRC];
      end
      if (sel_rel) reload <= bus_wdata[CNT_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)          flag <= 1'b0;
    else if (cur_wr)  flag <= 1'b0;
    else if (hit)     flag <= 1'b1;
    else if (ctrl_rd) flag <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
      irq   <= 1'b0;
    end else begin
      rdata <= bus_rd ? rd_mux : '0;
      irq   <= hit & ctrl.irq_en;
    end
  end

endmodule

// File: rtl/tick_timer.sv
module tick_timer
  import tick_timer_pkg::*;
#(
  parameter int unsigned CNT_W  = 24,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ref_tick,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq
);

  ctrl_t            ctrl_q;
  logic [CNT_W-1:0] reload_q;
  logic [CNT_W-1:0] cnt_q;
  logic             flag_q;
  logic             tick;
  logic             hit;
  logic             cur_wr;
  logic             ctrl_rd;

  tick_gate u_gate (
    .run      (ctrl_q.run),
    .src_core (ctrl_q.src_core),
    .ref_tick (ref_tick),
    .tick     (tick)
  );

  tick_core #(.CNT_W(CNT_W)) u_core (
    .clk    (clk),
    .rst    (rst),
    .tick   (tick),
    .clr    (cur_wr),
    .reload (reload_q),
    .cnt    (cnt_q),
    .hit    (hit)
  );

  tick_regs #(.CNT_W(CNT_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
    .clk       (clk),
    .rst       (rst),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .cnt       (cnt_q),
    .hit       (hit),
    .ctrl      (ctrl_q),
    .reload    (reload_q),
    .flag      (flag_q),
    .cur_wr    (cur_wr),
    .ctrl_rd   (ctrl_rd),
    .rdata     (bus_rdata),
    .irq       (irq)
  );

endmodule

// File: rtl/tick_timer_chk.sv
module tick_timer_chk #(
  parameter int unsigned CNT_W = 24
) (
  input logic             clk,
  input logic             rst,
  input logic             irq,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] reload,
  input logic             flag,
  input logic             run,
  input logic             tick,
  input logic             cur_wr,
  input logic             ctrl_rd
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  p_pulse_r9: assert property (@(posedge clk) disable iff (rst)
    irq |=> !irq);

  p_irq_at_zero_r9: assert property (@(posedge clk) disable iff (rst)
    irq |-> (cnt == '0 && flag));

  p_cur_write_r7: assert property (@(posedge clk) disable iff (rst)
    cur_wr |=> (cnt == '0 && !flag && !irq));

  p_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (!run && !cur_wr) |=> $stable(cnt));

  p_stop_r8: assert property (@(posedge clk) disable iff (rst)
    (cnt == '0 && reload == '0 && !cur_wr) |=> cnt == '0);

  p_step_r3: assert property (@(posedge clk) disable iff (rst)
    (tick && cnt != '0 && !cur_wr) |=> cnt == $past(cnt) - ONE);

  p_wrap_r4: assert property (@(posedge clk) disable iff (rst)
    (tick && cnt == '0 && !cur_wr) |=> cnt == $past(reload));

  p_set_r5: assert property (@(posedge clk) disable iff (rst)
    (tick && cnt == ONE && !cur_wr) |=> flag);

  p_rd_clear_r6: assert property (@(posedge clk) disable iff (rst)
    (ctrl_rd && !(tick && cnt == ONE)) |=> !flag);

endmodule

bind tick_timer tick_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .irq     (irq),
  .cnt     (cnt_q),
  .reload  (reload_q),
  .flag    (flag_q),
  .run     (ctrl_q.run),
  .tick    (tick),
  .cur_wr  (cur_wr),
  .ctrl_rd (ctrl_rd)
);

// File: tb/tb_tick_timer.sv
module tb_tick_timer;

  localparam int unsigned CNT_W  = 8;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned ADDR_W = 4;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              ref_tick = 1'b0;
  logic              bus_wr = 1'b0;
  logic              bus_rd = 1'b0;
  logic [ADDR_W-1:0] bus_addr = '0;
  logic [DATA_W-1:0] bus_wdata = '0;
  logic [DATA_W-1:0] bus_rdata;
  logic              irq;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #10 clk = ~clk;

  tick_timer #(.CNT_W(CNT_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) dut (
    .clk(clk), .rst(rst), .ref_tick(ref_tick),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  // behavioural reference model
  bit          m_en, m_ie, m_cs, m_flag, m_irq;
  int unsigned m_rel, m_cnt;
  logic [31:0] m_rdata;
  int          irq_seen;

  function automatic logic [31:0] m_read(int unsigned a);
    logic [31:0] v = 0;
    if (a == 0)      v = (32'(m_flag) << 16) | (32'(m_cs) << 2) | (32'(m_ie) << 1) | 32'(m_en);
    else if (a == 4) v = m_rel;
    else if (a == 8) v = m_cnt;
    return v;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_en = 0; m_ie = 0; m_cs = 0; m_flag = 0; m_irq = 0;
      m_rel = 0; m_cnt = 0; m_rdata = 0;
    end else begin
      bit tk, cw, hitm;
      int unsigned a;
      a    = bus_addr;
      tk   = m_en && (m_cs || ref_tick);
      cw   = bus_wr && a == 8;
      hitm = tk && m_cnt == 1 && !cw;
      m_rdata = bus_rd ? m_read(a) : 0;
      m_irq   = hitm && m_ie;
      if (cw)                        m_flag = 0;
      else if (hitm)                 m_flag = 1;
      else if (bus_rd && a == 0)     m_flag = 0;
      if (cw)      m_cnt = 0;
      else if (tk) m_cnt = (m_cnt == 0) ? m_rel : m_cnt - 1;
      if (bus_wr && a == 0) begin
        m_en = bus_wdata[0]; m_ie = bus_wdata[1]; m_cs = bus_wdata[2];
      end
      if (bus_wr && a == 4) m_rel = bus_wdata & 32'hFF;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model, away from the active edge
  always @(negedge clk) begin
    if (!rst && !done) begin
      chk(irq === m_irq, "R9 irq", 32'(irq), 32'(m_irq));
      chk(bus_rdata === m_rdata, "R2 rdata", bus_rdata, m_rdata);
      if (irq === 1'b1) irq_seen++;
    end
  end

  task automatic wr(input int unsigned a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = ADDR_W'(a); bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input int unsigned a, output logic [31:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = ADDR_W'(a);
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      bad++; total++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] v, v2;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk(irq === 1'b0, "R1 irq", 32'(irq), 0);
    rd(0, v); chk(v == 0, "R1 ctrl", v, 0);
    rd(4, v); chk(v == 0, "R1 reload", v, 0);
    rd(8, v); chk(v == 0, "R1 cur", v, 0);

    // R11 truncation
    wr(4, 32'h1FF);
    rd(4, v); chk(v == 32'hFF, "R11 reload width", v, 32'hFF);

    // R2 unused and misaligned
    rd(12, v); chk(v == 0, "R2 unused word", v, 0);
    rd(5, v);  chk(v == 0, "R2 misaligned", v, 0);

    // strobe mode: R3 / R4
    wr(4, 3);
    wr(0, 32'h3);
    idle(4);
    rd(8, v); chk(v == 0, "R3 no strobe hold", v, 0);
    @(negedge clk) ref_tick = 1'b1;
    @(negedge clk) ref_tick = 1'b0;
    rd(8, v); chk(v == 3, "R4 load on zero", v, 3);
    @(negedge clk) ref_tick = 1'b1;
    @(negedge clk) ref_tick = 1'b0;
    rd(8, v); chk(v == 2, "R3 strobe step", v, 2);

    // R7: write wins over tick, clears counter
    @(negedge clk) ref_tick = 1'b1;
    wr(8, 32'hDEAD);
    ref_tick = 1'b0;
    rd(8, v); chk(v == 0, "R7 cur cleared", v, 0);
    rd(0, v); chk(v[16] == 1'b0, "R7 flag clear", v, 0);

    // core clock: R5 / R6 / R10
    wr(0, 32'h7);
    idle(10);
    wr(0, 32'h2);
    rd(8, v); idle(3); rd(8, v2);
    chk(v == v2, "R10 hold", v2, v);
    rd(0, v);  chk(v == 32'h10002, "R5 flag set", v, 32'h10002);
    rd(0, v);  chk(v == 32'h00002, "R6 read clears", v, 32'h2);

    // R9: irq gated by enable
    wr(4, 1);
    irq_seen = 0;
    wr(0, 32'h5);
    idle(20);
    chk(irq_seen == 0, "R9 no irq when disabled", irq_seen, 0);
    wr(0, 32'h7);
    idle(20);
    chk(irq_seen > 5, "R9 irq pulses", irq_seen, 6);

    // R8: reload zero stops
    wr(4, 0);
    idle(6);
    rd(8, v); idle(4); rd(8, v2);
    chk(v == 0 && v2 == 0, "R8 stopped", v2, 0);

    // full-scale wrap
    wr(4, 32'hFF);
    idle(600);

    // random mix
    for (int i = 0; i < 3000; i++) begin
      int unsigned op;
      op = $urandom_range(0, 15);
      @(negedge clk);
      ref_tick  = 1'($urandom_range(0, 1));
      bus_wr    = 1'b0; bus_rd = 1'b0;
      bus_wdata = $urandom;
      case (op)
        0: begin bus_wr = 1'b1; bus_addr = 4'h8; end
        1: begin bus_wr = 1'b1; bus_addr = 4'h4; bus_wdata = 32'($urandom_range(0, 6)); end
        2: begin bus_wr = 1'b1; bus_addr = 4'h0; bus_wdata[0] = 1'b1; end
        3, 4, 5: begin bus_rd = 1'b1; bus_addr = 4'h0; end
        6: begin bus_rd = 1'b1; bus_addr = 4'h8; end
        7: begin bus_rd = 1'b1; bus_addr = 4'h4; end
        8: begin bus_rd = 1'b1; bus_addr = ADDR_W'($urandom_range(0, 15)); end
        default: ;
      endcase
    end
    @(negedge clk);
    bus_wr = 1'b0; bus_rd = 1'b0; ref_tick = 1'b0;
    idle(2);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule